// File: doc/BRIEF.md
# Masked Vector Expand Unit

This unit sits in a vector execution pipeline. It reads a densely packed source vector of 64-bit elements and spreads those elements, in order, across the destination lanes that a lane mask selects. Source element 0 goes to the lowest selected lane, source element 1 to the next selected lane, and so on. When masking is switched off, every active lane is selected, so the unit copies the low part of the source straight through.

A destination lane in the active length whose mask bit is clear either keeps its prior destination value (merge) or becomes zero (zeroing). Every bit above the active vector length is cleared. A 2-bit length code sets the number of active lanes. A 4-bit reserved specifier must be all ones. An illegal specifier or an illegal length code raises a one-cycle undefined-opcode fault in place of a result. The unit raises no floating-point exception conditions.

The unit registers its result one clock after the input strobe.

Top module: `lane_expand_unit`

## Requirements
- R1: Length code 0 gives 2 active 64-bit lanes (128 bits). Code 1 gives 4 lanes (256 bits). Code 2 gives 8 lanes (512 bits).
- R2: With masking enabled, a selected active lane j (lane j occupies bits 64j+63:64j) receives the source element whose index equals the number of selected active lanes below j. Source elements are therefore used in ascending order from source lane 0.
- R3: With masking disabled (mask_en = 0), every active lane is selected. Each active lane j receives source element j.
- R4: When zero_mode = 0 (merge), an active lane that is not selected keeps the value of the corresponding lane of old_vec.
- R5: When zero_mode = 1 (zeroing), an active lane that is not selected is driven to zero.
- R6: Every result bit at or above the active vector length is zero, for any mask, enable or merge setting.
- R7: Mask bits at lane positions at or above the active lane count have no effect and use no source element.
- R8: A rsvd_spec value other than 4'b1111 on a valid input produces fault = 1 and out_valid = 0 in the next cycle. out_vec does not change.
- R9: Length code 3 on a valid input raises the fault in the same way as R8.
- R10: out_valid and out_vec update exactly one clock after a valid, legal input. fault and out_valid are single-cycle pulses. out_vec keeps its value in every cycle without a valid legal input.
- R11: A synchronous active-low reset clears out_valid, fault and out_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input operation strobe |
| src_vec | input | 512 | Packed source elements |
| old_vec | input | 512 | Prior destination value for merging |
| lane_mask | input | 8 | Lane select mask, bit j for lane j |
| mask_en | input | 1 | 1: use lane_mask; 0: select all active lanes |
| zero_mode | input | 1 | 1: zero unselected lanes; 0: merge |
| len_code | input | 2 | Vector length code (0, 1, 2 legal) |
| rsvd_spec | input | 4 | Reserved specifier, must be 4'b1111 |
| out_valid | output | 1 | Result valid pulse |
| out_vec | output | 512 | Registered result |
| fault | output | 1 | Undefined-opcode fault pulse |

## Verification
The assertions check the control behaviour on every cycle:
- out_valid and fault never rise together.
- Illegal specifiers and length codes turn into fault pulses, and legal strobes turn into result pulses.
- out_vec holds between operations.
- For some recognisable operand patterns the whole result is fixed in advance: a straight copy when masking is off, cleared upper bits for the shortest length, an empty zeroing mask, and an empty merge mask.

The exact lane-by-lane placement of source elements for arbitrary masks can only be shown by the bench. It sweeps every mask value against every length, enable and merge setting and compares each result with an arithmetic model.

// File: rtl/lane_expand_pkg.sv
// Shared constants and types of the masked vector expand unit.
// Assumes: element width and lane count are fixed for the datapath that
// instantiates the unit; the length code is always two bits wide.
package lane_expand_pkg;
    localparam int EXP_ELEM_W = 64;
    localparam int EXP_LANES  = 8;
    localparam int EXP_SPEC_W = 4;

    typedef enum logic [1:0] {
        LEN_QUARTER = 2'd0,
        LEN_HALF    = 2'd1,
        LEN_FULL    = 2'd2,
        LEN_BAD     = 2'd3
    } len_code_e;
endpackage

// File: rtl/lane_expand_ctl.sv
// Control decode: derives the active-lane mask from the length code, the
// effective select mask from the lane mask and enable, and the illegal
// flag from the reserved specifier and length code.
// Assumes: LANES is divisible by 4.
module lane_expand_ctl
    import lane_expand_pkg::*;
#(
    parameter int LANES  = EXP_LANES,
    parameter int SPEC_W = EXP_SPEC_W
) (
    input  logic [LANES-1:0]  lane_mask,
    input  logic              mask_en,
    input  logic [1:0]        len_code,
    input  logic [SPEC_W-1:0] rsvd_spec,
    output logic [LANES-1:0]  active_mask,
    output logic [LANES-1:0]  eff_mask,
    output logic              illegal
);
    localparam int CNT_W = $clog2(LANES) + 1;

    logic [CNT_W-1:0] active_cnt;

    // Map the length code to a number of active lanes.
    always_comb begin
        case (len_code)
            LEN_QUARTER: active_cnt = CNT_W'(LANES / 4);
            LEN_HALF:    active_cnt = CNT_W'(LANES / 2);
            LEN_FULL:    active_cnt = CNT_W'(LANES);
            default:     active_cnt = '0;
        endcase
    end

    // Build a thermometer mask of the active lanes.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            active_mask[j] = (CNT_W'(j) < active_cnt);
        end
    end

    // Lanes that take a source element: active and (mask off or bit set).
    assign eff_mask = active_mask & (mask_en ? lane_mask : {LANES{1'b1}});

    // Undefined-opcode condition.
    assign illegal = (rsvd_spec != {SPEC_W{1'b1}}) || (len_code == LEN_BAD);
endmodule

// File: rtl/lane_expand_prefix.sv
// Prefix counter: for each lane, counts the selected lanes strictly below
// it. That count is the source element index the lane reads.
// Assumes: the top lane's own select bit is never needed, so only the
// lower LANES-1 bits are taken.
module lane_expand_prefix #(
    parameter int LANES = 8,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-2:0]       low_mask,
    output logic [LANES*IDX_W-1:0] idx_flat
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDX_W-1:0] cnt;

        // Population count of the select bits below lane j.
        always_comb begin
            cnt = '0;
            for (int b = 0; b < j; b++) begin
                cnt = cnt + IDX_W'(low_mask[b]);
            end
        end

        assign idx_flat[j*IDX_W +: IDX_W] = cnt;
    end
endmodule

// File: rtl/lane_expand_route.sv
// Lane router: each destination lane picks a source element, its old
// value, or zero, based on the active, select and zeroing controls.
// Assumes: LANES is a power of two so an index addresses every element.
module lane_expand_route #(
    parameter int ELEM_W = 64,
    parameter int LANES  = 8,
    parameter int IDX_W  = $clog2(LANES)
) (
    input  logic [ELEM_W*LANES-1:0] src_vec,
    input  logic [ELEM_W*LANES-1:0] old_vec,
    input  logic [LANES-1:0]        active_mask,
    input  logic [LANES-1:0]        eff_mask,
    input  logic                    zero_mode,
    input  logic [LANES*IDX_W-1:0]  idx_flat,
    output logic [ELEM_W*LANES-1:0] res_vec
);
    logic [ELEM_W-1:0] src_el [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDX_W-1:0]  sel;
        logic [ELEM_W-1:0] lane_val;

        assign src_el[j] = src_vec[j*ELEM_W +: ELEM_W];
        assign sel       = idx_flat[j*IDX_W +: IDX_W];

        // Choose the value that lane j takes.
        always_comb begin
            if (!active_mask[j])
                lane_val = '0;
            else if (eff_mask[j])
                lane_val = src_el[sel];
            else if (zero_mode)
                lane_val = '0;
            else
                lane_val = old_vec[j*ELEM_W +: ELEM_W];
        end

        assign res_vec[j*ELEM_W +: ELEM_W] = lane_val;
    end
endmodule

// File: rtl/lane_expand_unit.sv
// Masked vector expand unit, top level. It places packed source elements
// in ascending order into the selected destination lanes, merges or zeroes
// the other active lanes, clears lanes above the active length, and
// registers the result or a fault one clock after a valid input.
// Assumes: synchronous active-low reset; no back-pressure on the output.
module lane_expand_unit
    import lane_expand_pkg::*;
#(
    parameter int ELEM_W = EXP_ELEM_W,
    parameter int LANES  = EXP_LANES,
    parameter int SPEC_W = EXP_SPEC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [ELEM_W*LANES-1:0] src_vec,
    input  logic [ELEM_W*LANES-1:0] old_vec,
    input  logic [LANES-1:0]        lane_mask,
    input  logic                    mask_en,
    input  logic                    zero_mode,
    input  logic [1:0]              len_code,
    input  logic [SPEC_W-1:0]       rsvd_spec,
    output logic                    out_valid,
    output logic [ELEM_W*LANES-1:0] out_vec,
    output logic                    fault
);
    localparam int IDX_W = $clog2(LANES);
    localparam int VEC_W = ELEM_W * LANES;

    logic [LANES-1:0]       active_mask;
    logic [LANES-1:0]       eff_mask;
    logic                   illegal;
    logic [LANES*IDX_W-1:0] idx_flat;
    logic [VEC_W-1:0]       res_vec;

    lane_expand_ctl #(.LANES(LANES), .SPEC_W(SPEC_W)) u_ctl (
        .lane_mask   (lane_mask),
        .mask_en     (mask_en),
        .len_code    (len_code),
        .rsvd_spec   (rsvd_spec),
        .active_mask (active_mask),
        .eff_mask    (eff_mask),
        .illegal     (illegal)
    );

    lane_expand_prefix #(.LANES(LANES), .IDX_W(IDX_W)) u_prefix (
        .low_mask (eff_mask[LANES-2:0]),
        .idx_flat (idx_flat)
    );

    lane_expand_route #(.ELEM_W(ELEM_W), .LANES(LANES), .IDX_W(IDX_W)) u_route (
        .src_vec     (src_vec),
        .old_vec     (old_vec),
        .active_mask (active_mask),
        .eff_mask    (eff_mask),
        .zero_mode   (zero_mode),
        .idx_flat    (idx_flat),
        .res_vec     (res_vec)
    );

    // Result and fault strobes, one cycle after the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            fault     <= 1'b0;
        end else begin
            out_valid <= in_valid && !illegal;
            fault     <= in_valid && illegal;
        end
    end

    // Result register; loads only on a valid, legal operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_vec <= '0;
        else if (in_valid && !illegal)
            out_vec <= res_vec;
    end
endmodule

// File: rtl/lane_expand_chk.sv
// Checker for the masked vector expand unit, bound to every instance.
// Assumes: it sees the top-level ports only.
module lane_expand_chk #(
    parameter int ELEM_W = 64,
    parameter int LANES  = 8,
    parameter int SPEC_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [ELEM_W*LANES-1:0] src_vec,
    input logic [ELEM_W*LANES-1:0] old_vec,
    input logic [LANES-1:0]        lane_mask,
    input logic                    mask_en,
    input logic                    zero_mode,
    input logic [1:0]              len_code,
    input logic [SPEC_W-1:0]       rsvd_spec,
    input logic                    out_valid,
    input logic [ELEM_W*LANES-1:0] out_vec,
    input logic                    fault
);
    localparam int VEC_W = ELEM_W * LANES;
    localparam int Q_W   = (LANES / 4) * ELEM_W;

    logic legal_in;
    assign legal_in = (rsvd_spec == {SPEC_W{1'b1}}) && (len_code != 2'd3);

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && fault));

    // R8
    spec_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (rsvd_spec != {SPEC_W{1'b1}}) |=> fault && !out_valid);

    // R9
    len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (len_code == 2'd3) |=> fault && !out_valid);

    // R10
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal_in |=> out_valid && !fault);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !fault);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && legal_in) |=> $stable(out_vec));

    // R3
    plain_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal_in && !mask_en && (len_code == 2'd2)
        |=> out_vec == $past(src_vec));

    // R6
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal_in && (len_code == 2'd0)
        |=> out_vec[VEC_W-1:Q_W] == '0);

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal_in && mask_en && zero_mode && (lane_mask == '0)
        |=> out_vec == '0);

    // R4
    empty_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal_in && mask_en && !zero_mode && (lane_mask == '0)
        && (len_code == 2'd2)
        |=> out_vec == $past(old_vec));
endmodule

bind lane_expand_unit lane_expand_chk #(
    .ELEM_W (ELEM_W),
    .LANES  (LANES),
    .SPEC_W (SPEC_W)
) u_lane_expand_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_vec   (src_vec),
    .old_vec   (old_vec),
    .lane_mask (lane_mask),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .len_code  (len_code),
    .rsvd_spec (rsvd_spec),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .fault     (fault)
);

// File: tb/test_lane_expand_unit.sv
// Bench for the masked vector expand unit. It sweeps every mask value
// against every legal length, enable and merge setting, and compares
// each result with an arithmetic model.
module test_lane_expand_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [511:0] old_vec = '0;
    logic [7:0]   lane_mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic [1:0]   len_code = '0;
    logic [3:0]   rsvd_spec = 4'hF;
    logic         out_valid;
    logic [511:0] out_vec;
    logic         fault;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lane_expand_unit i_lane_expand_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src_vec   (src_vec),
        .old_vec   (old_vec),
        .lane_mask (lane_mask),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .len_code  (len_code),
        .rsvd_spec (rsvd_spec),
        .out_valid (out_valid),
        .out_vec   (out_vec),
        .fault     (fault)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] make_vec(input logic [15:0] tagv, input int seed);
        logic [511:0] v;
        for (int i = 0; i < 8; i++)
            v[i*64 +: 64] = {tagv, 16'(seed), 16'(seed * 7 + 3), 16'(i + 1)};
        return v;
    endfunction

    // Model from R1..R7: walk the lanes in ascending order with a source cursor.
    function automatic logic [511:0] model(input logic [511:0] s, input logic [511:0] o,
                                           input logic [7:0] m, input bit men,
                                           input bit zm, input int len);
        logic [511:0] r;
        int active;
        int k;
        active = 2 << len;
        k = 0;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            if (j < active) begin
                if (!men || m[j]) begin
                    r[j*64 +: 64] = s[k*64 +: 64];
                    k++;
                end else if (!zm) begin
                    r[j*64 +: 64] = o[j*64 +: 64];
                end
            end
        end
        return r;
    endfunction

    // Name the requirement that the first differing lane belongs to.
    function automatic string classify(input logic [511:0] a, input logic [511:0] e,
                                       input logic [7:0] m, input bit men,
                                       input bit zm, input int len);
        for (int j = 0; j < 8; j++) begin
            if (a[j*64 +: 64] != e[j*64 +: 64]) begin
                if (j >= (2 << len)) return "R6/R1";
                if (!men) return "R3";
                if (m[j]) return "R2/R7";
                if (zm) return "R5";
                return "R4";
            end
        end
        return "R2";
    endfunction

    task automatic run_op(input logic [511:0] s, input logic [511:0] o, input logic [7:0] m,
                          input bit men, input bit zm, input logic [1:0] len,
                          input logic [3:0] spec);
        @(negedge clk);
        src_vec = s; old_vec = o; lane_mask = m; mask_en = men;
        zero_mode = zm; len_code = len; rsvd_spec = spec; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin : main
        logic [511:0] s;
        logic [511:0] o;
        logic [511:0] e;
        logic [511:0] held;
        int seed;
        seed = 0;

        // R11: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 0 && fault == 0 && out_vec == '0, "R11 reset state",
              {out_valid, fault, out_vec[509:0]}, '0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7 R1: full sweep of masks, lengths, enable, merge
        for (int len = 0; len < 3; len++) begin
            for (int men = 0; men < 2; men++) begin
                for (int zm = 0; zm < 2; zm++) begin
                    for (int m = 0; m < 256; m++) begin
                        seed++;
                        s = make_vec(16'h5C00, seed);
                        o = make_vec(16'h0D00, seed);
                        run_op(s, o, 8'(m), bit'(men), bit'(zm), 2'(len), 4'hF);
                        e = model(s, o, 8'(m), bit'(men), bit'(zm), len);
                        check(out_valid == 1'b1 && fault == 1'b0, "R10 result pulse",
                              {510'd0, out_valid, fault}, 512'd2);
                        check(out_vec == e,
                              classify(out_vec, e, 8'(m), bit'(men), bit'(zm), len),
                              out_vec, e);
                    end
                end
            end
        end

        // R7: with len 0, mask bits 2..7 have no effect; lane 1 gets element 0
        s = make_vec(16'h7700, 1);
        o = make_vec(16'h8800, 1);
        run_op(s, o, 8'hFE, 1'b1, 1'b1, 2'd0, 4'hF);
        e = '0;
        e[127:64] = s[63:0];
        check(out_vec == e, "R7 high mask bits ignored", out_vec, e);

        // R10: idle cycle after a result: no pulse, result held
        held = out_vec;
        @(negedge clk);
        check(out_valid == 0 && fault == 0, "R10 single-cycle pulse",
              {510'd0, out_valid, fault}, '0);
        check(out_vec == held, "R10 result held", out_vec, held);

        // R8: every non-all-ones reserved specifier faults, result held
        for (int sp = 0; sp < 15; sp++) begin
            run_op(make_vec(16'h9900, sp), o, 8'hFF, 1'b1, 1'b0, 2'd2, 4'(sp));
            check(fault == 1'b1 && out_valid == 1'b0, "R8 specifier fault",
                  {510'd0, out_valid, fault}, 512'd1);
            check(out_vec == held, "R8 result unchanged", out_vec, held);
        end

        // R9: length code 3 faults; fault then drops (R10)
        run_op(make_vec(16'hAA00, 9), o, 8'hFF, 1'b0, 1'b0, 2'd3, 4'hF);
        check(fault == 1'b1 && out_valid == 1'b0, "R9 length fault",
              {510'd0, out_valid, fault}, 512'd1);
        check(out_vec == held, "R9 result unchanged", out_vec, held);
        @(negedge clk);
        check(fault == 1'b0, "R10 fault pulse ends", {511'd0, fault}, '0);

        // R11: reset wins over a valid input in the same cycle
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        len_code = 2'd2;
        rsvd_spec = 4'hF;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 0 && fault == 0 && out_vec == '0, "R11 reset over valid",
              {out_valid, fault, out_vec[509:0]}, '0);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end
endmodule